// File: doc/BRIEF.md
# Acquisition Interrupt and Status Controller

This block gathers the three event sources of a data-acquisition board (end of a channel-list scan, FIFO almost-full threshold and timer overflow) into a single interrupt request line for the host. Each source owns a sticky event flag and a separate enable bit. A flag is set whenever its event pulse arrives, whether or not the source is enabled, so the host can either take interrupts or poll. The request line is high while any flag is set together with its enable.

The host uses a small register bus with a write side and a read side. Writes reach the control registers that hold the enables. Reads return the status registers that hold the flags. The end-of-scan and FIFO flags clear as a side effect of reading their status register. The timer flag ignores reads entirely. It clears only when the host writes its enable bit to zero, which also disables the timer interrupt. When the scan list holds a single channel, every conversion counts as the end of a scan.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all enables and all event flags are zero, `irq` is low, and both status registers read as zero.
- R2: A one-cycle `scan_done` pulse sets the end-of-scan flag. A `conv_done` pulse sets nothing while `single_chan` is 0.
- R3: While `single_chan` is 1, a `conv_done` pulse also sets the end-of-scan flag.
- R4: A one-cycle `fifo_afull` pulse sets the FIFO flag.
- R5: Event flags set regardless of their enable, and a set flag with a cleared enable leaves `irq` low.
- R6: A read at offset 2 returns the end-of-scan flag in bit 0 and the FIFO flag in bit 1, with the other bits zero. It clears both flags from the next cycle on.
- R7: If an event pulse coincides with the clearing read at offset 2, its flag remains set after that read.
- R8: A read at offset 15 returns the timer flag in bit 4, with the other bits zero, and does not clear it.
- R9: The timer flag clears after a write at offset 15 with bit 5 equal to 0. A write with bit 5 equal to 1 leaves it set. A `tmr_ovf` pulse in the same cycle as the clearing write keeps it set.
- R10: A write at offset 2 loads the end-of-scan enable from bit 0 and the FIFO enable from bit 1. A write at offset 15 loads the timer enable from bit 5.
- R11: `irq` is the OR over all sources of flag AND enable. It is high in the cycle after the event pulse's clock edge when that source is enabled.
- R12: Writes to any other offset change no enable. Reads at any other offset, and idle cycles with `bus_rd` low, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| single_chan | input | 1 | Scan list has one entry |
| scan_done | input | 1 | End-of-scan pulse |
| conv_done | input | 1 | End-of-conversion pulse |
| fifo_afull | input | 1 | FIFO almost-full pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| irq | output | 1 | Host interrupt request |

## Verification
The bench targets the collisions between an event and its clear. If the clear won, an end-of-scan or timer event arriving during a status read or a disabling write would be lost for good. It also checks that a read of the auxiliary status leaves the timer flag set, which catches a design that treats all flags the same way. It checks that `conv_done` counts only in single-channel mode, which catches a wrongly wired scan source. It checks that writes to other offsets leave the enables alone, since a loose address decode would raise `irq` unbidden.

// File: rtl/acq_irq_pkg.sv
// Shared constants for the acquisition interrupt controller.
// Assumes an 8-bit data bus; bit positions below are host-visible layout.
package acq_irq_pkg;
    localparam int NUM_SRC = 3;
    localparam int IDX_EOS  = 0;
    localparam int IDX_FIFO = 1;
    localparam int IDX_TMR  = 2;

    localparam int CTRL_EOS_EN_BIT  = 0;
    localparam int CTRL_FIFO_EN_BIT = 1;
    localparam int AUX_TMR_EN_BIT   = 5;
    localparam int STAT_EOS_BIT     = 0;
    localparam int STAT_FIFO_BIT    = 1;
    localparam int AUX_TMR_FLAG_BIT = 4;
endpackage

// File: rtl/acq_irq_flag.sv
// Sticky event flag: set by a pulse, cleared by a strobe, set wins on collision.
// Assumes set and clr are synchronous single-cycle strobes.
module acq_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag; a new event overrides a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_FLAG_SETS:  assert property (@(posedge clk) disable iff (!rst_n) set |=> q);                  // R7
    AST_FLAG_CLRS:  assert property (@(posedge clk) disable iff (!rst_n) (clr && !set) |=> !q);       // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!set && !clr) |=> (q == $past(q))); // R5
endmodule

// File: rtl/acq_irq_regif.sv
// Host register interface: enable registers on the write side, flag status
// on the read side, and per-source clear strobes derived from bus access.
// Assumes bus_wr and bus_rd are single-cycle strobes; read data is combinational.
module acq_irq_regif
    import acq_irq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CTRL_OFF = 2,
    parameter int AUX_OFF  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] clr,
    output logic [DATA_W-1:0]  bus_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] AUX_A  = ADDR_W'(AUX_OFF);

    logic hit_ctrl, hit_aux;
    logic unused_wbits;

    assign hit_ctrl     = (bus_addr == CTRL_A);
    assign hit_aux      = (bus_addr == AUX_A);
    assign unused_wbits = ^bus_wdata;

    // Load enables from writes to the two control offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (bus_wr && hit_ctrl) begin
                en_q[IDX_EOS]  <= bus_wdata[CTRL_EOS_EN_BIT];
                en_q[IDX_FIFO] <= bus_wdata[CTRL_FIFO_EN_BIT];
            end
            if (bus_wr && hit_aux)
                en_q[IDX_TMR] <= bus_wdata[AUX_TMR_EN_BIT];
        end
    end

    // Derive clears: status read for scan/FIFO, disabling write for timer.
    always_comb begin
        clr           = '0;
        clr[IDX_EOS]  = bus_rd && hit_ctrl;
        clr[IDX_FIFO] = bus_rd && hit_ctrl;
        clr[IDX_TMR]  = bus_wr && hit_aux && !bus_wdata[AUX_TMR_EN_BIT];
    end

    // Return the addressed status register during a read, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit_ctrl) begin
            bus_rdata[STAT_EOS_BIT]  = flag_q[IDX_EOS];
            bus_rdata[STAT_FIFO_BIT] = flag_q[IDX_FIFO];
        end else if (bus_rd && hit_aux) begin
            bus_rdata[AUX_TMR_FLAG_BIT] = flag_q[IDX_TMR];
        end
    end

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ctrl) |=> (en_q[IDX_EOS] == $past(bus_wdata[CTRL_EOS_EN_BIT])));   // R10
    AST_EN_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || (!hit_ctrl && !hit_aux)) |=> $stable(en_q));                           // R12
    AST_IDLE_RD:  assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));                                                     // R12
endmodule

// File: rtl/acq_irq_merge.sv
// Combines flags with enables into the single host interrupt request.
// Assumes both vectors come from registers, so irq is glitch-free at the edge.
module acq_irq_merge
    import acq_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flag_q,
    input  logic [NUM_SRC-1:0] en_q,
    output logic               irq
);
    // Request when any enabled source has its flag raised.
    always_comb irq = |(flag_q & en_q);

    AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);                                                            // R5
endmodule

// File: rtl/acq_irq_ctrl.sv
// Top: acquisition interrupt and status controller. Maps event pulses to
// sticky flags, exposes them on a small register bus, and drives irq.
// Assumes all event inputs are synchronous single-cycle pulses.
module acq_irq_ctrl
    import acq_irq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CTRL_OFF = 2,
    parameter int AUX_OFF  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              single_chan,
    input  logic              scan_done,
    input  logic              conv_done,
    input  logic              fifo_afull,
    input  logic              tmr_ovf,
    output logic              irq
);
    logic [NUM_SRC-1:0] ev;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;

    // Route pulses to sources; one-channel lists count each conversion as a scan.
    always_comb begin
        ev           = '0;
        ev[IDX_EOS]  = scan_done || (single_chan && conv_done);
        ev[IDX_FIFO] = fifo_afull;
        ev[IDX_TMR]  = tmr_ovf;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        acq_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (ev[i]),
            .clr   (clr[i]),
            .q     (flag_q[i])
        );
    end

    acq_irq_regif #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_OFF (CTRL_OFF),
        .AUX_OFF  (AUX_OFF)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .flag_q    (flag_q),
        .en_q      (en_q),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    acq_irq_merge u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_q (flag_q),
        .en_q   (en_q),
        .irq    (irq)
    );

    AST_TMR_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(AUX_OFF) && flag_q[IDX_TMR]) |=> flag_q[IDX_TMR]); // R8
    AST_CONV_IGNORED:  assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !single_chan && !scan_done && !flag_q[IDX_EOS]) |=> !flag_q[IDX_EOS]);         // R2
    AST_STAT_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(CTRL_OFF) && !fifo_afull) |=> !flag_q[IDX_FIFO]);             // R6
endmodule

// File: tb/tb_acq_irq_ctrl.sv
module tb_acq_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       single_chan = 1'b0, scan_done = 1'b0, conv_done = 1'b0;
    logic       fifo_afull = 1'b0, tmr_ovf = 1'b0;
    logic       irq;
    int         n_checks = 0;
    int         n_errors = 0;

    always #5 clk = ~clk;

    acq_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .single_chan(single_chan), .scan_done(scan_done), .conv_done(conv_done),
        .fifo_afull(fifo_afull), .tmr_ovf(tmr_ovf), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge; one posedge consumes them.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        {scan_done, conv_done, fifo_afull, tmr_ovf} = '0;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
    endtask

    // Read: sample combinational data mid-cycle, then let the edge apply side effects.
    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        step();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd(4'd2, d);  check("R1 status", d, 8'h00);
        rd(4'd15, d); check("R1 aux status", d, 8'h00);
        check("R12 idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_eos();
        logic [7:0] d;
        scan_done = 1'b1; step();
        check("R5 flag set but disabled", {7'b0, irq}, 8'h00);
        rd(4'd2, d); check("R2 R6 eos flag bit0", d, 8'h01);
        rd(4'd2, d); check("R6 cleared by read", d, 8'h00);
        conv_done = 1'b1; step();
        rd(4'd2, d); check("R2 conv ignored multi-channel", d, 8'h00);
        single_chan = 1'b1;
        conv_done = 1'b1; step();
        rd(4'd2, d); check("R3 conv is scan end single-channel", d, 8'h01);
        single_chan = 1'b0;
    endtask

    task automatic t_fifo();
        logic [7:0] d;
        fifo_afull = 1'b1; step();
        rd(4'd2, d); check("R4 fifo flag bit1", d, 8'h02);
        wr(4'd2, 8'h02);
        check("R10 enable alone no irq", {7'b0, irq}, 8'h00);
        fifo_afull = 1'b1; step();
        check("R11 irq fifo enabled", {7'b0, irq}, 8'h01);
        rd(4'd2, d);
        check("R6 irq drops after read", {7'b0, irq}, 8'h00);
        wr(4'd2, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        scan_done = 1'b1; step();
        bus_addr = 4'd2; bus_rd = 1'b1; scan_done = 1'b1;
        #1 d = bus_rdata;
        step();
        check("R7 read shows old flag", d, 8'h01);
        rd(4'd2, d); check("R7 new event survives read", d, 8'h01);
    endtask

    task automatic t_timer();
        logic [7:0] d;
        wr(4'd15, 8'h20);
        tmr_ovf = 1'b1; step();
        check("R11 irq timer", {7'b0, irq}, 8'h01);
        rd(4'd15, d); check("R8 timer flag bit4", d, 8'h10);
        rd(4'd15, d); check("R8 read does not clear", d, 8'h10);
        rd(4'd2, d);  check("R8 status read leaves timer", {7'b0, irq}, 8'h01);
        wr(4'd15, 8'h20);
        rd(4'd15, d); check("R9 enable=1 write keeps flag", d, 8'h10);
        wr(4'd15, 8'h00);
        check("R9 irq off after disable", {7'b0, irq}, 8'h00);
        rd(4'd15, d); check("R9 flag cleared by disable", d, 8'h00);
        tmr_ovf = 1'b1; step();
        bus_addr = 4'd15; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_ovf = 1'b1;
        step();
        rd(4'd15, d); check("R9 overflow beats clearing write", d, 8'h10);
        wr(4'd15, 8'h00);
    endtask

    task automatic t_other();
        logic [7:0] d;
        scan_done = 1'b1; fifo_afull = 1'b1; step();
        wr(4'd5, 8'hFF);
        check("R12 stray write no enable", {7'b0, irq}, 8'h00);
        rd(4'd5, d); check("R12 stray read zero", d, 8'h00);
        wr(4'd2, 8'h01);
        check("R10 eos enable bit0", {7'b0, irq}, 8'h01);
        rd(4'd2, d); check("R6 both flags", d, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_eos();
        t_fifo();
        t_collide();
        t_timer();
        t_other();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule